// File: doc/BRIEF.md
# DRAM Command Spacing Tracker

This block watches the commands a memory channel has just sent to its DRAM devices. It answers one question every DRAM clock: may a candidate READ or REFRESH to a given rank and bank go out now? The block remembers recent row activations, writes, reads, precharge-all commands and refreshes. It compares the time since each of them against minimum gaps programmed in two configuration words, and drives a single allow flag for the candidate.

Each gap is tracked at the scope it applies to. Activate-to-read is kept for every rank-bank pair. Write-to-read and read-to-read come in two forms: one held for the rank that was addressed, and one held for every other rank. Precharge-all-to-refresh and refresh-to-refresh are kept for each rank. An arbiter presents a candidate each cycle and reports each command it issues. The allow flag is a combinational function of the candidate and of the state left by earlier commands.

Top module: `dram_spacing_tracker`

## Requirements
- R1: Reset clears all tracked history. After reset is released, any READ or REFRESH candidate is allowed, even if a long gap was still pending before reset.
- R2: A programmed gap of 0 or 1 never blocks a candidate presented in the cycle after the command that started the gap.
- R3: After an ACT (command code 0) to rank r, bank b, with gap field `cfgRd[20:17]` = N, a READ candidate (code 1) to the same rank and bank is refused until N cycles have passed since the ACT. Other banks of that rank, and the same bank of other ranks, are not affected.
- R4: After a WRITE (code 2) to rank r, with 5-bit gap `cfgRd[16:12]` = N, a READ candidate to rank r is refused for fewer than N cycles since the WRITE.
- R5: After a WRITE to rank r, with gap `cfgRd[11:8]` = N, a READ candidate to any other rank is refused for fewer than N cycles. This field does not affect READs to rank r.
- R6: After a READ to rank r, with gap `cfgRd[7:4]` = N, a READ candidate to rank r is refused for fewer than N cycles.
- R7: After a READ to rank r, with gap `cfgRd[3:0]` = N, a READ candidate to any other rank is refused for fewer than N cycles.
- R8: After a PRE-ALL (code 3) to rank r, with gap `cfgRf[12:9]` = N, a REFRESH candidate (code 4) to rank r is refused for fewer than N cycles. Other ranks are not affected.
- R9: After a REFRESH to rank r, with 9-bit gap `cfgRf[8:0]` = N, a REFRESH candidate to rank r is refused for fewer than N cycles.
- R10: A READ candidate is allowed only when every gap that applies to it has expired. Each gap runs from its own command.
- R11: A command and a candidate in the same cycle: the candidate is judged on the state before that command.
- R12: Candidates with a code other than READ or REFRESH are always reported as allowed.
- R13: The reserved bits `cfgRd[23:21]` and `cfgRf[15:13]` have no effect on the allow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | A command is issued this cycle |
| issueCmd | input | 3 | Issued command code (0 ACT, 1 READ, 2 WRITE, 3 PRE-ALL, 4 REFRESH) |
| issueRank | input | RANK_W | Rank of the issued command |
| issueBank | input | BANK_W | Bank of the issued command |
| qryCmd | input | 3 | Candidate command code |
| qryRank | input | RANK_W | Candidate rank |
| qryBank | input | BANK_W | Candidate bank |
| cfgRd | input | 24 | Read-side spacing fields |
| cfgRf | input | 16 | Refresh-side spacing fields |
| qryAllow | output | 1 | Candidate may issue this cycle |

## Verification
The assertions assume three things about the inputs: the configuration words hold steady while a gap they started is running, at most one command is reported per cycle, and candidate ranks lie inside the configured rank count. The bench writes the configuration only after an idle stretch longer than the largest gap. It reports commands one at a time from a single task, and it uses only ranks 0 and 1 on the two-rank default. Under those conditions each property states that a command with a gap of at least two refuses a matching candidate in the cycle that follows.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [2:0] {
    CMD_ACT    = 3'd0,
    CMD_READ   = 3'd1,
    CMD_WRITE  = 3'd2,
    CMD_PREALL = 3'd3,
    CMD_REF    = 3'd4
  } cmd_e;

  // strobes from control to datapath: which counter family to load
  typedef struct packed {
    logic act;
    logic wr;
    logic rd;
    logic pall;
    logic refr;
  } load_s;

  // field placement inside the read-side configuration word
  localparam int ACT_RD_LSB  = 17;
  localparam int ACT_RD_W    = 4;
  localparam int WR_SAME_LSB = 12;
  localparam int WR_SAME_W   = 5;
  localparam int WR_DIFF_LSB = 8;
  localparam int WR_DIFF_W   = 4;
  localparam int RD_SAME_LSB = 4;
  localparam int RD_SAME_W   = 4;
  localparam int RD_DIFF_LSB = 0;
  localparam int RD_DIFF_W   = 4;

  // field placement inside the refresh-side configuration word
  localparam int PALL_LSB = 9;
  localparam int PALL_W   = 4;
  localparam int REF_LSB  = 0;
  localparam int REF_W    = 9;

endpackage

// File: rtl/spc_downcnt.sv
module spc_downcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] span,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (span == '0) ? '0 : span - W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - W'(1);
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/spc_datapath.sv
module spc_datapath
  import spc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int RANK_W    = 1,
  parameter int BANK_W    = 3
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  load_s                                loads,
  input  logic [RANK_W-1:0]                    issueRank,
  input  logic [BANK_W-1:0]                    issueBank,
  input  logic [23:0]                          cfgRd,
  input  logic [15:0]                          cfgRf,
  output logic [NUM_RANKS-1:0][NUM_BANKS-1:0]  actZero,
  output logic [NUM_RANKS-1:0]                 wrSameZero,
  output logic [NUM_RANKS-1:0]                 wrDiffZero,
  output logic [NUM_RANKS-1:0]                 rdSameZero,
  output logic [NUM_RANKS-1:0]                 rdDiffZero,
  output logic [NUM_RANKS-1:0]                 pallZero,
  output logic [NUM_RANKS-1:0]                 refZero
);

  logic [ACT_RD_W-1:0]  actSpan;
  logic [WR_SAME_W-1:0] wrSameSpan;
  logic [WR_DIFF_W-1:0] wrDiffSpan;
  logic [RD_SAME_W-1:0] rdSameSpan;
  logic [RD_DIFF_W-1:0] rdDiffSpan;
  logic [PALL_W-1:0]    pallSpan;
  logic [REF_W-1:0]     refSpan;
  logic                 unusedCfg;

  assign actSpan    = cfgRd[ACT_RD_LSB  +: ACT_RD_W];
  assign wrSameSpan = cfgRd[WR_SAME_LSB +: WR_SAME_W];
  assign wrDiffSpan = cfgRd[WR_DIFF_LSB +: WR_DIFF_W];
  assign rdSameSpan = cfgRd[RD_SAME_LSB +: RD_SAME_W];
  assign rdDiffSpan = cfgRd[RD_DIFF_LSB +: RD_DIFF_W];
  assign pallSpan   = cfgRf[PALL_LSB    +: PALL_W];
  assign refSpan    = cfgRf[REF_LSB     +: REF_W];
  assign unusedCfg  = ^{cfgRd[23:21], cfgRf[15:13]};

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic hitRank;
    assign hitRank = (issueRank == RANK_W'(r));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      spc_downcnt #(.W(ACT_RD_W)) u_act (
        .clk(clk), .rstN(rstN),
        .load(loads.act && hitRank && (issueBank == BANK_W'(b))),
        .span(actSpan), .zero(actZero[r][b]));
    end

    spc_downcnt #(.W(WR_SAME_W)) u_wrSame (
      .clk(clk), .rstN(rstN), .load(loads.wr && hitRank),
      .span(wrSameSpan), .zero(wrSameZero[r]));
    spc_downcnt #(.W(WR_DIFF_W)) u_wrDiff (
      .clk(clk), .rstN(rstN), .load(loads.wr && !hitRank),
      .span(wrDiffSpan), .zero(wrDiffZero[r]));
    spc_downcnt #(.W(RD_SAME_W)) u_rdSame (
      .clk(clk), .rstN(rstN), .load(loads.rd && hitRank),
      .span(rdSameSpan), .zero(rdSameZero[r]));
    spc_downcnt #(.W(RD_DIFF_W)) u_rdDiff (
      .clk(clk), .rstN(rstN), .load(loads.rd && !hitRank),
      .span(rdDiffSpan), .zero(rdDiffZero[r]));
    spc_downcnt #(.W(PALL_W)) u_pall (
      .clk(clk), .rstN(rstN), .load(loads.pall && hitRank),
      .span(pallSpan), .zero(pallZero[r]));
    spc_downcnt #(.W(REF_W)) u_ref (
      .clk(clk), .rstN(rstN), .load(loads.refr && hitRank),
      .span(refSpan), .zero(refZero[r]));
  end

endmodule

// File: rtl/spc_ctrl.sv
module spc_ctrl
  import spc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int RANK_W    = 1,
  parameter int BANK_W    = 3
) (
  input  logic                                 issueValid,
  input  logic [2:0]                           issueCmd,
  input  logic [2:0]                           qryCmd,
  input  logic [RANK_W-1:0]                    qryRank,
  input  logic [BANK_W-1:0]                    qryBank,
  input  logic [NUM_RANKS-1:0][NUM_BANKS-1:0]  actZero,
  input  logic [NUM_RANKS-1:0]                 wrSameZero,
  input  logic [NUM_RANKS-1:0]                 wrDiffZero,
  input  logic [NUM_RANKS-1:0]                 rdSameZero,
  input  logic [NUM_RANKS-1:0]                 rdDiffZero,
  input  logic [NUM_RANKS-1:0]                 pallZero,
  input  logic [NUM_RANKS-1:0]                 refZero,
  output load_s                                loads,
  output logic                                 qryAllow
);

  always_comb begin
    loads      = '0;
    loads.act  = issueValid && (issueCmd == CMD_ACT);
    loads.wr   = issueValid && (issueCmd == CMD_WRITE);
    loads.rd   = issueValid && (issueCmd == CMD_READ);
    loads.pall = issueValid && (issueCmd == CMD_PREALL);
    loads.refr = issueValid && (issueCmd == CMD_REF);
  end

  always_comb begin
    unique case (qryCmd)
      CMD_READ: qryAllow = actZero[qryRank][qryBank] && wrSameZero[qryRank] &&
                           wrDiffZero[qryRank] && rdSameZero[qryRank] &&
                           rdDiffZero[qryRank];
      CMD_REF:  qryAllow = pallZero[qryRank] && refZero[qryRank];
      default:  qryAllow = 1'b1;
    endcase
  end

endmodule

// File: rtl/dram_spacing_tracker.sv
module dram_spacing_tracker
  import spc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [2:0]        issueCmd,
  input  logic [RANK_W-1:0] issueRank,
  input  logic [BANK_W-1:0] issueBank,
  input  logic [2:0]        qryCmd,
  input  logic [RANK_W-1:0] qryRank,
  input  logic [BANK_W-1:0] qryBank,
  input  logic [23:0]       cfgRd,
  input  logic [15:0]       cfgRf,
  output logic              qryAllow
);

  load_s                                loads;
  logic [NUM_RANKS-1:0][NUM_BANKS-1:0]  actZero;
  logic [NUM_RANKS-1:0]                 wrSameZero, wrDiffZero;
  logic [NUM_RANKS-1:0]                 rdSameZero, rdDiffZero;
  logic [NUM_RANKS-1:0]                 pallZero, refZero;

  spc_ctrl #(
    .NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS),
    .RANK_W(RANK_W), .BANK_W(BANK_W)
  ) u_ctrl (
    .issueValid(issueValid), .issueCmd(issueCmd),
    .qryCmd(qryCmd), .qryRank(qryRank), .qryBank(qryBank),
    .actZero(actZero), .wrSameZero(wrSameZero), .wrDiffZero(wrDiffZero),
    .rdSameZero(rdSameZero), .rdDiffZero(rdDiffZero),
    .pallZero(pallZero), .refZero(refZero),
    .loads(loads), .qryAllow(qryAllow)
  );

  spc_datapath #(
    .NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS),
    .RANK_W(RANK_W), .BANK_W(BANK_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .loads(loads),
    .issueRank(issueRank), .issueBank(issueBank),
    .cfgRd(cfgRd), .cfgRf(cfgRf),
    .actZero(actZero), .wrSameZero(wrSameZero), .wrDiffZero(wrDiffZero),
    .rdSameZero(rdSameZero), .rdDiffZero(rdDiffZero),
    .pallZero(pallZero), .refZero(refZero)
  );

endmodule

// File: rtl/spc_checker.sv
module spc_checker
  import spc_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  localparam int RANK_W = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              issueValid,
  input logic [2:0]        issueCmd,
  input logic [RANK_W-1:0] issueRank,
  input logic [BANK_W-1:0] issueBank,
  input logic [2:0]        qryCmd,
  input logic [RANK_W-1:0] qryRank,
  input logic [BANK_W-1:0] qryBank,
  input logic [23:0]       cfgRd,
  input logic [15:0]       cfgRf,
  input logic              qryAllow
);

  a_r3_act_blocks_bank: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_ACT && cfgRd[20:17] >= 4'd2) |=>
    !(qryCmd == CMD_READ && qryRank == $past(issueRank) &&
      qryBank == $past(issueBank) && qryAllow));

  a_r4_wr_same_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_WRITE && cfgRd[16:12] >= 5'd2) |=>
    !(qryCmd == CMD_READ && qryRank == $past(issueRank) && qryAllow));

  a_r5_wr_diff_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_WRITE && cfgRd[11:8] >= 4'd2) |=>
    !(qryCmd == CMD_READ && qryRank != $past(issueRank) && qryAllow));

  a_r6_rd_same_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_READ && cfgRd[7:4] >= 4'd2) |=>
    !(qryCmd == CMD_READ && qryRank == $past(issueRank) && qryAllow));

  a_r7_rd_diff_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_READ && cfgRd[3:0] >= 4'd2) |=>
    !(qryCmd == CMD_READ && qryRank != $past(issueRank) && qryAllow));

  a_r8_pall_blocks_ref: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_PREALL && cfgRf[12:9] >= 4'd2) |=>
    !(qryCmd == CMD_REF && qryRank == $past(issueRank) && qryAllow));

  a_r9_ref_blocks_ref: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && issueCmd == CMD_REF && cfgRf[8:0] >= 9'd2) |=>
    !(qryCmd == CMD_REF && qryRank == $past(issueRank) && qryAllow));

  a_r12_untracked_allowed: assert property (@(posedge clk) disable iff (!rstN)
    (qryCmd != CMD_READ && qryCmd != CMD_REF) |-> qryAllow);

endmodule

bind dram_spacing_tracker spc_checker #(
  .NUM_RANKS(NUM_RANKS), .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueCmd(issueCmd),
  .issueRank(issueRank), .issueBank(issueBank), .qryCmd(qryCmd),
  .qryRank(qryRank), .qryBank(qryBank), .cfgRd(cfgRd), .cfgRf(cfgRf),
  .qryAllow(qryAllow)
);

// File: tb/tb_dram_spacing_tracker.sv
module tb_dram_spacing_tracker;
  import spc_pkg::*;

  localparam int RW = 1;
  localparam int BW = 3;
  localparam int SETTLE = 520;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [2:0]    issueCmd = 3'd0;
  logic [RW-1:0] issueRank = '0;
  logic [BW-1:0] issueBank = '0;
  logic [2:0]    qryCmd = 3'd1;
  logic [RW-1:0] qryRank = '0;
  logic [BW-1:0] qryBank = '0;
  logic [23:0]   cfgRd = '0;
  logic [15:0]   cfgRf = '0;
  logic          qryAllow;

  int nChk = 0;
  int nBad = 0;

  dram_spacing_tracker dut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueCmd(issueCmd),
    .issueRank(issueRank), .issueBank(issueBank), .qryCmd(qryCmd),
    .qryRank(qryRank), .qryBank(qryBank), .cfgRd(cfgRd), .cfgRf(cfgRf),
    .qryAllow(qryAllow)
  );

  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    #(20 * 190000);
    nBad++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    summary();
    $finish;
  end

  task automatic check(input logic act, input logic exp, input string tag);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: qryAllow=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic query(input logic [2:0] c, input int r, input int b);
    qryCmd = c; qryRank = RW'(r); qryBank = BW'(b);
    #1;
  endtask

  // issue one command; returns at the negedge one cycle after it
  task automatic issue(input logic [2:0] c, input int r, input int b);
    @(negedge clk);
    issueValid = 1'b1; issueCmd = c; issueRank = RW'(r); issueBank = BW'(b);
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  // checks the candidate for gaps 1..v+1 after the command
  task automatic gapCheck(input logic [2:0] c, input int ir, input int ib,
                          input logic [2:0] qc, input int qr, input int qb,
                          input int v, input string tag);
    issue(c, ir, ib);
    for (int g = 1; g <= v + 1; g++) begin
      query(qc, qr, qb);
      check(qryAllow, g >= v, tag);
      @(negedge clk);
    end
  endtask

  task automatic setCfg(input logic [23:0] rd, input logic [15:0] rf);
    idle(SETTLE);
    cfgRd = rd; cfgRf = rf;
    @(negedge clk);
  endtask

  task automatic t_reset();
    query(CMD_READ, 0, 0); check(qryAllow, 1'b1, "R1 read after reset");
    query(CMD_REF, 1, 0);  check(qryAllow, 1'b1, "R1 ref after reset");
    setCfg(24'h0, 16'd300);
    issue(CMD_REF, 1, 0);
    query(CMD_REF, 1, 0); check(qryAllow, 1'b0, "R1 ref pending before reset");
    rstN = 1'b0; idle(2); rstN = 1'b1; @(negedge clk);
    query(CMD_REF, 1, 0); check(qryAllow, 1'b1, "R1 ref cleared by reset");
  endtask

  task automatic t_small();
    setCfg({3'b0, 4'd1, 5'd1, 4'd0, 4'd1, 4'd0}, {3'b0, 4'd1, 9'd0});
    gapCheck(CMD_ACT, 0, 1, CMD_READ, 0, 1, 1, "R2 act gap 1");
    gapCheck(CMD_WRITE, 0, 0, CMD_READ, 0, 0, 1, "R2 wr gap 1");
    gapCheck(CMD_WRITE, 0, 0, CMD_READ, 1, 0, 0, "R2 wr diff gap 0");
    gapCheck(CMD_REF, 1, 0, CMD_REF, 1, 0, 0, "R2 ref gap 0");
  endtask

  task automatic t_act();
    setCfg({3'b0, 4'd5, 17'd0}, 16'd0);
    gapCheck(CMD_ACT, 0, 3, CMD_READ, 0, 3, 5, "R3 act to read same bank");
    issue(CMD_ACT, 1, 6);
    query(CMD_READ, 1, 5); check(qryAllow, 1'b1, "R3 other bank free");
    query(CMD_READ, 0, 6); check(qryAllow, 1'b1, "R3 other rank free");
    query(CMD_READ, 1, 6); check(qryAllow, 1'b0, "R3 target bank held");
  endtask

  task automatic t_wrSame();
    setCfg({7'd0, 5'd17, 12'd0}, 16'd0);
    gapCheck(CMD_WRITE, 1, 0, CMD_READ, 1, 4, 17, "R4 write to read same rank");
    issue(CMD_WRITE, 1, 0);
    query(CMD_READ, 0, 0); check(qryAllow, 1'b1, "R4 other rank free");
  endtask

  task automatic t_wrDiff();
    setCfg({12'd0, 4'd6, 8'd0}, 16'd0);
    gapCheck(CMD_WRITE, 0, 0, CMD_READ, 1, 2, 6, "R5 write to read other rank");
    issue(CMD_WRITE, 0, 0);
    query(CMD_READ, 0, 0); check(qryAllow, 1'b1, "R5 same rank free");
  endtask

  task automatic t_rdSame();
    setCfg({16'd0, 4'd9, 4'd0}, 16'd0);
    gapCheck(CMD_READ, 0, 7, CMD_READ, 0, 1, 9, "R6 read to read same rank");
    issue(CMD_READ, 0, 7);
    query(CMD_READ, 1, 7); check(qryAllow, 1'b1, "R6 other rank free");
  endtask

  task automatic t_rdDiff();
    setCfg({20'd0, 4'd15}, 16'd0);
    gapCheck(CMD_READ, 1, 0, CMD_READ, 0, 0, 15, "R7 read to read other rank");
    issue(CMD_READ, 1, 0);
    query(CMD_READ, 1, 0); check(qryAllow, 1'b1, "R7 same rank free");
  endtask

  task automatic t_pall();
    setCfg(24'd0, {3'b0, 4'd7, 9'd0});
    gapCheck(CMD_PREALL, 1, 0, CMD_REF, 1, 0, 7, "R8 prechargeall to refresh");
    issue(CMD_PREALL, 1, 0);
    query(CMD_REF, 0, 0); check(qryAllow, 1'b1, "R8 other rank free");
  endtask

  task automatic t_ref();
    setCfg(24'd0, {7'd0, 9'd300});
    gapCheck(CMD_REF, 0, 0, CMD_REF, 0, 0, 300, "R9 refresh to refresh");
    issue(CMD_REF, 0, 0);
    query(CMD_REF, 1, 0); check(qryAllow, 1'b1, "R9 other rank free");
  endtask

  task automatic t_combined();
    setCfg({3'b0, 4'd3, 5'd6, 12'd0}, 16'd0);
    @(negedge clk);
    issueValid = 1'b1; issueCmd = CMD_ACT; issueRank = '0; issueBank = 3'd2;
    @(negedge clk);
    issueCmd = CMD_WRITE; issueBank = 3'd0;
    @(negedge clk);
    issueValid = 1'b0;
    for (int g = 1; g <= 7; g++) begin
      query(CMD_READ, 0, 2);
      check(qryAllow, (g >= 6) && (g + 1 >= 3), "R10 act and write both apply");
      if (g == 1) begin
        query(CMD_READ, 0, 5); check(qryAllow, 1'b0, "R10 write alone blocks");
      end
      @(negedge clk);
    end
  endtask

  task automatic t_sameCycle();
    setCfg({3'b0, 4'd4, 17'd0}, 16'd0);
    @(negedge clk);
    issueValid = 1'b1; issueCmd = CMD_ACT; issueRank = 1'b1; issueBank = 3'd6;
    query(CMD_READ, 1, 6); check(qryAllow, 1'b1, "R11 same cycle sees old state");
    @(negedge clk);
    issueValid = 1'b0;
    query(CMD_READ, 1, 6); check(qryAllow, 1'b0, "R11 next cycle sees command");
  endtask

  task automatic t_other();
    setCfg(24'h0F_FFFF, 16'h1FFF);
    issue(CMD_WRITE, 0, 0);
    issue(CMD_ACT, 0, 0);
    issue(CMD_PREALL, 0, 0);
    query(CMD_ACT, 0, 0);    check(qryAllow, 1'b1, "R12 act candidate");
    query(CMD_WRITE, 0, 0);  check(qryAllow, 1'b1, "R12 write candidate");
    query(CMD_PREALL, 0, 0); check(qryAllow, 1'b1, "R12 prechargeall candidate");
    query(3'd7, 0, 0);       check(qryAllow, 1'b1, "R12 unused code");
    query(CMD_READ, 0, 0);   check(qryAllow, 1'b0, "R12 read still tracked");
  endtask

  task automatic t_reserved();
    setCfg(24'hE0_0000, 16'hE000);
    issue(CMD_ACT, 0, 0);
    issue(CMD_WRITE, 0, 0);
    issue(CMD_READ, 1, 0);
    issue(CMD_PREALL, 1, 0);
    issue(CMD_REF, 0, 0);
    query(CMD_READ, 0, 0); check(qryAllow, 1'b1, "R13 read rank0 reserved bits");
    query(CMD_READ, 1, 0); check(qryAllow, 1'b1, "R13 read rank1 reserved bits");
    query(CMD_REF, 1, 0);  check(qryAllow, 1'b1, "R13 ref rank1 reserved bits");
    query(CMD_REF, 0, 0);  check(qryAllow, 1'b1, "R13 ref rank0 reserved bits");
  endtask

  initial begin
    cfgRd = 24'hFF_FFFF; cfgRf = 16'hFFFF;
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    cfgRd = '0; cfgRf = '0;
    t_reset();
    t_small();
    t_act();
    t_wrSame();
    t_wrDiff();
    t_rdSame();
    t_rdDiff();
    t_pall();
    t_ref();
    t_combined();
    t_sameCycle();
    t_other();
    t_reserved();
    idle(4);
    summary();
    $finish;
  end

endmodule